// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block runs an external 8-bit successive-approximation converter that has an 8-way analog input selector built in. It visits the active channels in ascending order and repeats. For each channel it does four things. It drives the 3-bit channel select. It latches that select with a one-period strobe. It fires a one-period start strobe. It then follows the converter's busy handshake: the conversion-done flag must fall and then rise again. After the rise it waits one converter clock period, raises the read enable, and reads the 8-bit result into the per-channel result bank. The block also makes the converter clock by dividing the system clock.

The conversion-done flag comes from outside this clock domain, so it passes through a two-flop synchronizer before any edge is detected. A conversion can hang because the flag never falls or never comes back high. In that case a wait limit, counted in converter clocks, raises a one-cycle timeout, drops that channel and moves on. Set `NUM_CH` to 4 to hold the top select bit at 0 and cycle through channels 0 to 3 only.

The sequencer has seven named states, shown here as the transitions between them:
- `ST_SETUP` → `ST_LATCH` on a converter-clock tick. This is the select setup period.
- `ST_LATCH` → `ST_KICK` on a tick. The latch strobe is high in `ST_LATCH`.
- `ST_KICK` → `ST_WAIT_LOW` on a tick. The start strobe is high in `ST_KICK`.
- `ST_WAIT_LOW` → `ST_WAIT_HIGH` when the flag falls.
- `ST_WAIT_HIGH` → `ST_OE_DELAY` when the flag rises.
- `ST_OE_DELAY` → `ST_READ` on a tick.
- `ST_READ` → `ST_SETUP` on a tick. The read enable is high in `ST_READ`, and the result is captured on the tick.
- `ST_WAIT_LOW` or `ST_WAIT_HIGH` → `ST_SETUP` when the wait limit expires.

Top module: `adc_seq_ctrl`

## Requirements
- R1: Channels are served in ascending order from 0 to NUM_CH-1 and then wrap to 0. The select is driven on `ch_addr`, with bit 0 as the least significant. With NUM_CH = 4, `ch_addr[2]` is always 0.
- R2: `ale` is high for exactly one converter clock period (2·DIV_HALF system cycles). `ch_addr` does not change while `ale` is high.
- R3: `start` rises on the same edge on which `ale` falls. It stays high for exactly one converter clock period.
- R4: The read enable is raised only after the conversion-done flag has been seen low since the last fall of `start`.
- R5: `oe` rises on the first converter clock rising edge after the synchronized rise of `eoc`. This falls between 3 and 3+2·DIV_HALF system cycles after `eoc` rises, and `eoc` is still high at that point.
- R6: The value on `data_in` is captured on the edge that ends the `oe` period. `sample_valid` pulses for one cycle just after that edge, together with `sample_data` and `sample_ch`. `oe` is low from that cycle on.
- R7: Each capture updates only the slice of `ch_regs` for its own channel. Channel c sits in bits [8c+7:8c]. All other slices keep their values.
- R8: Suppose the flag has not completed its fall-then-rise sequence within TIMEOUT_CLKS converter clock rising edges after `start` falls. Then `timeout` pulses on that edge, with `sample_ch` naming the channel. No valid pulse is given for that channel, and the next channel follows.
- R9: During reset, `adc_clk`, `ale`, `start`, `oe`, `ch_addr`, `sample_valid`, `timeout` and `ch_regs` are all 0.
- R10: `adc_clk` has a period of 2·DIV_HALF system cycles and is high for DIV_HALF cycles of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_clk | output | 1 | Divided clock for the converter |
| ch_addr | output | 3 | Channel select, bit 0 least significant |
| ale | output | 1 | Select latch strobe |
| start | output | 1 | Conversion start strobe |
| oe | output | 1 | Converter read enable |
| eoc | input | 1 | Conversion-done flag, asynchronous |
| data_in | input | 8 | Converter result bus |
| sample_data | output | 8 | Last captured result |
| sample_ch | output | 3 | Channel of the last capture or timeout |
| sample_valid | output | 1 | One-cycle pulse for a new result |
| timeout | output | 1 | One-cycle pulse when a channel wait expires |
| ch_regs | output | NUM_CH*8 | Latest result of every channel |

## Verification
Every result depends on the converter clock, so each check is tied to a rising edge of `adc_clk` and not to a fixed delay.
- The strobe widths are due exactly 2·DIV_HALF system cycles after their rising edge.
- The read enable is due 3 to 3+2·DIV_HALF cycles after the done flag rises. The 3 covers the two synchronizer flops and the state register; the remainder covers the wait for the next divider tick.
- The capture and its valid pulse are due one converter period after the read enable rises.
- A timeout is due on the TIMEOUT_CLKS-th converter clock rising edge counted from the fall of `start`.

The monitors sample on the falling system edge and count those edges to check each of these delays. A behavioural converter with one channel that never starts and another whose flag sticks low covers both timeout paths. It also covers the case where the flag rises again while `start` is still high.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        ST_SETUP,
        ST_LATCH,
        ST_KICK,
        ST_WAIT_LOW,
        ST_WAIT_HIGH,
        ST_OE_DELAY,
        ST_READ
    } seq_state_e;

endpackage

// File: rtl/adc_clk_gen.sv
module adc_clk_gen #(
    parameter int DIV_HALF = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic cclk_o,
    output logic tick_o
);

    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          cclk;
    logic          at_last;

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            cclk <= 1'b0;
        end else if (at_last) begin
            cnt  <= '0;
            cclk <= ~cclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

    // tick marks the system cycle whose closing edge raises cclk
    assign tick_o = at_last & ~cclk;
    assign cclk_o = cclk;

    // R10
    tick_raises_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> cclk_o);

    // R10
    clk_rise_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_o) |-> $past(tick_o));

endmodule

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic s1, s2, s3;

    // idle level of the flag is high, so reset to 1 to avoid a false fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= eoc_async_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign level_o = s2;
    assign rise_o  = s2 & ~s3;
    assign fall_o  = ~s2 & s3;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int TIMEOUT_CLKS = 80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              eoc_fall_i,
    input  logic              eoc_rise_i,
    output logic [ADDR_W-1:0] ch_o,
    output logic              ale_o,
    output logic              start_o,
    output logic              oe_o,
    output logic              capture_o,
    output logic              timeout_o
);

    localparam int TW = $clog2(TIMEOUT_CLKS + 1);
    localparam logic [TW-1:0]     WAIT_LAST = TW'(TIMEOUT_CLKS - 1);
    localparam logic [ADDR_W-1:0] CH_LAST   = ADDR_W'(NUM_CH - 1);

    seq_state_e        state, state_nxt;
    logic [ADDR_W-1:0] ch;
    logic [TW-1:0]     wait_cnt;
    logic              waiting;
    logic              expire;
    logic              advance;

    assign waiting = (state == ST_WAIT_LOW) || (state == ST_WAIT_HIGH);
    assign expire  = waiting && tick_i && (wait_cnt == WAIT_LAST);
    assign advance = expire || ((state == ST_READ) && tick_i);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_SETUP:     if (tick_i) state_nxt = ST_LATCH;
            ST_LATCH:     if (tick_i) state_nxt = ST_KICK;
            ST_KICK:      if (tick_i) state_nxt = ST_WAIT_LOW;
            ST_WAIT_LOW:  if (expire) state_nxt = ST_SETUP;
                          else if (eoc_fall_i) state_nxt = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (expire) state_nxt = ST_SETUP;
                          else if (eoc_rise_i) state_nxt = ST_OE_DELAY;
            ST_OE_DELAY:  if (tick_i) state_nxt = ST_READ;
            ST_READ:      if (tick_i) state_nxt = ST_SETUP;
            default:      state_nxt = ST_SETUP;
        endcase
    end

    // state register with the channel pointer and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SETUP;
            ch       <= '0;
            wait_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (advance) ch <= (ch == CH_LAST) ? '0 : ch + 1'b1;
            if (!waiting)    wait_cnt <= '0;
            else if (tick_i) wait_cnt <= wait_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        ch_o      = ch;
        ale_o     = (state == ST_LATCH);
        start_o   = (state == ST_KICK);
        oe_o      = (state == ST_READ);
        capture_o = (state == ST_READ) && tick_i;
        timeout_o = expire;
    end

    // R2
    addr_held_in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |=> (ale_o ? $stable(ch_o) : 1'b1));

    // R3
    start_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale_o) |-> start_o);

    // R6
    capture_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture_o |-> oe_o);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int NUM_CH       = 8,
    parameter int DIV_HALF     = 100,
    parameter int TIMEOUT_CLKS = 80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     adc_clk,
    output logic [ADDR_W-1:0]        ch_addr,
    output logic                     ale,
    output logic                     start,
    output logic                     oe,
    input  logic                     eoc,
    input  logic [DATA_W-1:0]        data_in,
    output logic [DATA_W-1:0]        sample_data,
    output logic [ADDR_W-1:0]        sample_ch,
    output logic                     sample_valid,
    output logic                     timeout,
    output logic [NUM_CH*DATA_W-1:0] ch_regs
);

    logic tick;
    logic eoc_level, eoc_rise, eoc_fall;
    logic capture, expire;

    adc_clk_gen #(.DIV_HALF(DIV_HALF)) u_clk_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .cclk_o (adc_clk),
        .tick_o (tick)
    );

    adc_eoc_sync u_eoc_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoc_async_i (eoc),
        .level_o     (eoc_level),
        .rise_o      (eoc_rise),
        .fall_o      (eoc_fall)
    );

    adc_seq_fsm #(.NUM_CH(NUM_CH), .TIMEOUT_CLKS(TIMEOUT_CLKS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .eoc_fall_i (eoc_fall),
        .eoc_rise_i (eoc_rise),
        .ch_o       (ch_addr),
        .ale_o      (ale),
        .start_o    (start),
        .oe_o       (oe),
        .capture_o  (capture),
        .timeout_o  (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_data  <= '0;
            sample_ch    <= '0;
            sample_valid <= 1'b0;
            timeout      <= 1'b0;
        end else begin
            sample_valid <= capture;
            timeout      <= expire;
            if (capture) sample_data <= data_in;
            if (capture || expire) sample_ch <= ch_addr;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        logic [DATA_W-1:0] slot;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    slot <= '0;
            else if (capture && ch_addr == ADDR_W'(g))     slot <= data_in;
        end
        assign ch_regs[g*DATA_W +: DATA_W] = slot;
    end

    // R1
    addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ch_addr) < NUM_CH);

    // R5
    oe_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> eoc_level);

    // R6
    valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> ($past(oe) && !oe));

    // R8
    timeout_not_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !sample_valid);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps

package adc_seq_tb_pkg;
    function automatic logic [7:0] conv_value(input int ch, input int k);
        logic [7:0] v;
        v = 8'(ch * 37 + k * 11 + 5);
        return v ^ 8'h5A;
    endfunction
endpackage

module adc_conv_model
    import adc_seq_tb_pkg::*;
#(
    parameter logic [7:0] NOFALL = 8'h00,
    parameter logic [7:0] STUCK  = 8'h00,
    parameter int LAG  = 2,
    parameter int CONV = 64
) (
    input  logic       adc_clk,
    input  logic       ale,
    input  logic       start,
    input  logic       oe,
    input  logic [2:0] addr,
    output logic       eoc,
    output logic [7:0] dout
);
    logic [2:0] lat     = 3'd0;
    logic       start_q = 1'b0;
    logic       eoc_r   = 1'b1;
    logic [7:0] result  = 8'h00;
    bit         busy    = 1'b0;
    int         cnt     = 0;
    int         k [8]   = '{default: 0};

    always @(negedge adc_clk) begin
        if (ale) lat = addr;
        if (start && !start_q) begin
            eoc_r = 1'b1;
            busy  = 1'b0;
        end else if (!start && start_q && !NOFALL[lat]) begin
            busy = 1'b1;
            cnt  = 0;
        end else if (busy) begin
            cnt++;
            if (cnt == LAG) eoc_r = 1'b0;
            if (cnt == LAG + CONV) begin
                busy = 1'b0;
                if (!STUCK[lat]) begin
                    result = conv_value(int'(lat), k[lat]);
                    k[lat]++;
                    eoc_r = 1'b1;
                end
            end
        end
        start_q = start;
    end

    assign eoc  = eoc_r;
    assign dout = oe ? result : 8'h00;
endmodule

module adc_seq_mon
    import adc_seq_tb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DH     = 2,
    parameter int TMO    = 80,
    parameter logic [7:0] FAULTS = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adc_clk,
    input  logic [2:0]          ch_addr,
    input  logic                ale,
    input  logic                start,
    input  logic                oe,
    input  logic                eoc,
    input  logic [7:0]          sample_data,
    input  logic [2:0]          sample_ch,
    input  logic                sample_valid,
    input  logic                timeout,
    input  logic [NUM_CH*8-1:0] ch_regs,
    output int                  n_chk,
    output int                  n_bad,
    output int                  rounds
);
    int  exp_ch = 0;
    int  k [8] = '{default: 0};
    logic [7:0] shadow [8] = '{default: 8'h00};
    logic adc_p = 0, ale_p = 0, start_p = 0, oe_p = 0, eoc_p = 1;
    int  per = 0, hi = 0, ale_w = 0, start_w = 0, since_eoc = 0, rises = 0;
    bit  seen_rise = 0, addr_moved = 0, saw_low = 0;
    logic [2:0] ale_addr = 0;

    initial begin n_chk = 0; n_bad = 0; rounds = 0; end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic next_ch();
        exp_ch = (exp_ch == NUM_CH - 1) ? 0 : exp_ch + 1;
        if (exp_ch == 0) rounds++;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            // R10 converter clock shape
            per++;
            if (adc_clk) hi++;
            if (adc_clk && !adc_p) begin
                if (seen_rise) chk(per == 2 * DH, "R10 period", per, 2 * DH);
                seen_rise = 1; per = 0; rises++;
            end
            if (!adc_clk && adc_p) begin
                chk(hi == DH, "R10 high time", hi, DH);
                hi = 0;
            end
            // R1 / R2 latch strobe
            if (ale && !ale_p) begin
                chk(int'(ch_addr) == exp_ch, "R1 channel order", ch_addr, exp_ch);
                if (NUM_CH == 4) chk(ch_addr[2] == 1'b0, "R1 top select bit", ch_addr[2], 0);
                ale_addr = ch_addr; addr_moved = 0; ale_w = 0;
            end
            if (ale) begin
                ale_w++;
                if (ch_addr != ale_addr) addr_moved = 1;
            end
            if (!ale && ale_p) begin
                chk(ale_w == 2 * DH, "R2 latch width", ale_w, 2 * DH);
                chk(!addr_moved, "R2 select stable", addr_moved, 0);
                chk(start, "R3 start follows latch", start, 1);
            end
            // R3 start strobe
            if (start) start_w++;
            if (!start && start_p) begin
                chk(start_w == 2 * DH, "R3 start width", start_w, 2 * DH);
                start_w = 0; rises = 0; saw_low = 0;
            end
            if (!start && !eoc) saw_low = 1;
            // R5 read enable timing
            since_eoc++;
            if (eoc && !eoc_p) since_eoc = 0;
            if (oe && !oe_p) begin
                chk(saw_low, "R4 low seen before read", saw_low, 1);
                chk(eoc, "R5 flag high at read", eoc, 1);
                chk(since_eoc >= 3 && since_eoc <= 3 + 2 * DH, "R5 read delay",
                    since_eoc, 3 + 2 * DH);
            end
            // R6 / R7 capture
            if (sample_valid) begin
                logic [7:0] ev;
                ev = conv_value(exp_ch, k[exp_ch]);
                chk(!FAULTS[exp_ch], "R8 faulty channel gave data", exp_ch, -1);
                chk(int'(sample_ch) == exp_ch, "R6 sample channel", sample_ch, exp_ch);
                chk(sample_data == ev, "R6 sample data", sample_data, ev);
                chk(oe_p && !oe, "R6 read enable ends at capture", {oe_p, oe}, 2);
                shadow[exp_ch] = ev;
                for (int i = 0; i < NUM_CH; i++)
                    chk(ch_regs[i*8 +: 8] == shadow[i], "R7 result bank",
                        ch_regs[i*8 +: 8], shadow[i]);
                k[exp_ch]++;
                next_ch();
            end
            // R8 timeout
            if (timeout) begin
                chk(FAULTS[exp_ch], "R8 unexpected timeout", exp_ch, -1);
                chk(int'(sample_ch) == exp_ch, "R8 timeout channel", sample_ch, exp_ch);
                chk(rises == TMO, "R8 timeout edge", rises, TMO);
                chk(!sample_valid, "R8 no valid", sample_valid, 0);
                next_ch();
            end
        end
        adc_p = adc_clk; ale_p = ale; start_p = start; oe_p = oe; eoc_p = eoc;
    end
endmodule

module adc_seq_ctrl_tb;
    logic clk = 0;
    logic rst_n = 0;
    always #2.5 clk = ~clk;

    localparam int DH_A = 2, DH_B = 3, TMO = 80;

    logic       a_adc, a_ale, a_start, a_oe, a_eoc, a_valid, a_tmo;
    logic [2:0] a_addr, a_sch;
    logic [7:0] a_din, a_sd;
    logic [31:0] a_regs;
    logic       b_adc, b_ale, b_start, b_oe, b_eoc, b_valid, b_tmo;
    logic [2:0] b_addr, b_sch;
    logic [7:0] b_din, b_sd;
    logic [63:0] b_regs;

    adc_seq_ctrl #(.NUM_CH(4), .DIV_HALF(DH_A), .TIMEOUT_CLKS(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .adc_clk(a_adc), .ch_addr(a_addr), .ale(a_ale),
        .start(a_start), .oe(a_oe), .eoc(a_eoc), .data_in(a_din), .sample_data(a_sd),
        .sample_ch(a_sch), .sample_valid(a_valid), .timeout(a_tmo), .ch_regs(a_regs));

    adc_seq_ctrl #(.NUM_CH(8), .DIV_HALF(DH_B), .TIMEOUT_CLKS(TMO)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .adc_clk(b_adc), .ch_addr(b_addr), .ale(b_ale),
        .start(b_start), .oe(b_oe), .eoc(b_eoc), .data_in(b_din), .sample_data(b_sd),
        .sample_ch(b_sch), .sample_valid(b_valid), .timeout(b_tmo), .ch_regs(b_regs));

    adc_conv_model #(.NOFALL(8'h04), .STUCK(8'h00)) u_model_a (
        .adc_clk(a_adc), .ale(a_ale), .start(a_start), .oe(a_oe), .addr(a_addr),
        .eoc(a_eoc), .dout(a_din));

    adc_conv_model #(.NOFALL(8'h00), .STUCK(8'h20)) u_model_b (
        .adc_clk(b_adc), .ale(b_ale), .start(b_start), .oe(b_oe), .addr(b_addr),
        .eoc(b_eoc), .dout(b_din));

    int a_chk, a_bad, a_rounds, b_chk, b_bad, b_rounds;

    adc_seq_mon #(.NUM_CH(4), .DH(DH_A), .TMO(TMO), .FAULTS(8'h04)) u_mon_a (
        .clk(clk), .rst_n(rst_n), .adc_clk(a_adc), .ch_addr(a_addr), .ale(a_ale),
        .start(a_start), .oe(a_oe), .eoc(a_eoc), .sample_data(a_sd), .sample_ch(a_sch),
        .sample_valid(a_valid), .timeout(a_tmo), .ch_regs(a_regs),
        .n_chk(a_chk), .n_bad(a_bad), .rounds(a_rounds));

    adc_seq_mon #(.NUM_CH(8), .DH(DH_B), .TMO(TMO), .FAULTS(8'h20)) u_mon_b (
        .clk(clk), .rst_n(rst_n), .adc_clk(b_adc), .ch_addr(b_addr), .ale(b_ale),
        .start(b_start), .oe(b_oe), .eoc(b_eoc), .sample_data(b_sd), .sample_ch(b_sch),
        .sample_valid(b_valid), .timeout(b_tmo), .ch_regs(b_regs),
        .n_chk(b_chk), .n_bad(b_bad), .rounds(b_rounds));

    int checks = 0;
    int fails  = 0;

    task automatic rchk(input bit ok, input string what, input int act);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R9 %s: actual %0d expected 0", what, act);
        end
    endtask

    initial begin
        int cyc;
        repeat (4) @(negedge clk);
        // R9 reset state of both configurations
        rchk({a_adc, a_ale, a_start, a_oe, a_valid, a_tmo} == 6'b0, "4-ch strobes",
             {a_adc, a_ale, a_start, a_oe, a_valid, a_tmo});
        rchk(a_addr == 3'd0, "4-ch select", a_addr);
        rchk(a_regs == 32'd0, "4-ch bank", int'(a_regs != 0));
        rchk({b_adc, b_ale, b_start, b_oe, b_valid, b_tmo} == 6'b0, "8-ch strobes",
             {b_adc, b_ale, b_start, b_oe, b_valid, b_tmo});
        rchk(b_addr == 3'd0, "8-ch select", b_addr);
        rchk(b_regs == 64'd0, "8-ch bank", int'(b_regs != 0));
        rst_n = 1;
        cyc = 0;
        while (!(a_rounds >= 3 && b_rounds >= 2) && cyc < 150000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual rounds %0d/%0d expected 3/2", a_rounds, b_rounds);
        end
        repeat (2) @(negedge clk);
        checks += a_chk + b_chk;
        fails  += a_bad + b_bad;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule